// File: doc/BRIEF.md
# Configuration Access and Register Preload Controller

This block sits between a test or programming port and the configuration storage of a small programmable logic array. It accepts one command per clock through a strobed command interface. A command can write or verify a byte of the configuration pattern, force one output register to a chosen level, or read or write a byte of an eight-byte user signature.

A one-way security bit protects the pattern. Once a lock command has been accepted, pattern verify reads and register preloads are refused. A refused read returns zero data with a denial flag set. A refused preload leaves every register untouched. Signature reads and writes stay open whatever the lock state. Only a full-erase command clears the lock, and that command also wipes the pattern.

Every accepted command produces a one-cycle response on the cycle after it is taken.

Top module: `plc_cfg_access`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid` and all `pre_load` strobes are 0, `pre_data` is all zero, the lock is clear, and every pattern word and signature byte reads as zero.
- R2: A command presented with `cmd_valid`=1 at a rising edge produces `rsp_valid`=1 for exactly the next cycle. Commands may be issued back to back every cycle. No response appears in a cycle that follows an edge without `cmd_valid`.
- R3: Opcode 0 writes `cmd_wdata` into pattern word `cmd_addr`, whether or not the lock is set. Opcode 1 reads that word into `rsp_rdata` with `rsp_denied`=0 while the lock is clear.
- R4: While the lock is clear, opcode 2 raises only `pre_load[cmd_addr[2:0]]` for one cycle, aligned with `rsp_valid`. In the same cycle `pre_data` for that register takes `cmd_wdata[0]` (1 = force high, 0 = force low). The other `pre_data` bits hold their values.
- R5: Opcode 5 sets the lock. The command accepted on the very next edge already sees the lock.
- R6: While the lock is set, opcode 1 responds with `rsp_rdata`=0 and `rsp_denied`=1.
- R7: While the lock is set, opcode 2 responds with `rsp_denied`=1. It raises no `pre_load` strobe and leaves `pre_data` unchanged.
- R8: Opcode 4 writes and opcode 3 reads signature byte `cmd_addr[2:0]`, with `rsp_denied`=0 in both lock states.
- R9: Opcode 6 clears the lock and every pattern word to zero in one step. The signature is retained.
- R10: Opcodes 0, 4, 5, 6 and 7 respond with `rsp_rdata`=0 and `rsp_denied`=0. Opcode 7 changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode (0 pattern write, 1 pattern read, 2 preload, 3 signature read, 4 signature write, 5 lock, 6 erase, 7 reserved) |
| cmd_addr | input | $clog2(PAT_WORDS) | Pattern word, signature byte (low 3 bits) or register index |
| cmd_wdata | input | DATA_W | Write data; bit 0 is the preload level |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Read data |
| rsp_denied | output | 1 | Command refused by the lock |
| pre_load | output | NREG | One-cycle per-register preload strobe |
| pre_data | output | NREG | Per-register preload level |

## Verification
The assertions assume that `cmd_op` and `cmd_addr` are known whenever `cmd_valid` is high. They also assume reset is held for at least one edge before the first command. The stimulus drives all inputs on the falling edge from a seeded random source, so every field is a defined value. Directed sequences place a refused read or preload on the edge right after a lock command, and run signature traffic while the lock is set. Erase is drawn rarely, so the random mix spends long stretches in both lock states.

// File: rtl/plc_cfg_pkg.sv
// Shared opcode encoding for the configuration access controller.
// Assumes a 3-bit opcode field; every code has a defined meaning.
package plc_cfg_pkg;
    typedef enum logic [2:0] {
        OP_PAT_WR  = 3'd0,
        OP_PAT_RD  = 3'd1,
        OP_PRELOAD = 3'd2,
        OP_SIG_RD  = 3'd3,
        OP_SIG_WR  = 3'd4,
        OP_LOCK    = 3'd5,
        OP_ERASE   = 3'd6,
        OP_RSVD    = 3'd7
    } cfg_op_e;
endpackage

// File: rtl/plc_cfg_lock.sv
// One-way security bit: set by a lock command and cleared only by an erase.
// Assumes set and clear never arrive together (they are distinct opcodes).
module plc_cfg_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic locked_o
);
    logic lock_q;

    // Holds the security state; erase has priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n)     lock_q <= 1'b0;
        else if (clr_i) lock_q <= 1'b0;
        else if (set_i) lock_q <= 1'b1;
    end

    assign locked_o = lock_q;

    assert_lock_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> locked_o);
    assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && !clr_i) |=> locked_o);
    assert_erase_unlocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !locked_o);
endmodule

// File: rtl/plc_cfg_bytes.sv
// Word-addressed byte store with one write port, a whole-array clear and an
// asynchronous read port. Used for both the pattern and the signature.
// Assumes WORDS is a power of two, so every address is in range.
module plc_cfg_bytes #(
    parameter  int WORDS = 32,
    parameter  int WIDTH = 8,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             clr,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [WORDS];

    // Storage update: reset and clear blank every word, otherwise write one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    assert_clear_blanks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rd_data == '0));
endmodule

// File: rtl/plc_cfg_preload.sv
// Per-register preload driver: one lane per output register, each lane
// holding a one-cycle strobe and the level to force.
// Assumes fire_i is already qualified by the lock.
module plc_cfg_preload #(
    parameter  int NREG = 8,
    localparam int IW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire_i,
    input  logic [IW-1:0]   idx_i,
    input  logic            val_i,
    output logic [NREG-1:0] strobe_o,
    output logic [NREG-1:0] data_o
);
    for (genvar g = 0; g < NREG; g++) begin : g_lane
        logic stb_q;
        logic val_q;
        logic hit;
        assign hit = fire_i && (idx_i == IW'(g));

        // Lane register: pulse on a hit and capture the level to force.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stb_q <= 1'b0;
                val_q <= 1'b0;
            end else begin
                stb_q <= hit;
                if (hit) val_q <= val_i;
            end
        end

        assign strobe_o[g] = stb_q;
        assign data_o[g]   = val_q;
    end

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe_o));
    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> ($stable(data_o) && strobe_o == '0));
endmodule

// File: rtl/plc_cfg_access.sv
// Configuration access controller top: decodes one command per cycle and
// steers it to the pattern store, signature store, lock bit or preload lanes.
// The lock gates pattern reads and preloads. The response is registered and
// appears one cycle after the command. Assumes PAT_WORDS >= 8 and NREG <= 8.
module plc_cfg_access #(
    parameter  int PAT_WORDS = 32,
    parameter  int DATA_W    = 8,
    parameter  int NREG      = 8,
    parameter  int SIG_BYTES = 8,
    localparam int AW        = $clog2(PAT_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_denied,
    output logic [NREG-1:0]   pre_load,
    output logic [NREG-1:0]   pre_data
);
    import plc_cfg_pkg::*;

    localparam int SW = $clog2(SIG_BYTES);
    localparam int IW = $clog2(NREG);

    cfg_op_e           op;
    logic              locked;
    logic              gated;
    logic [DATA_W-1:0] pat_rd;
    logic [DATA_W-1:0] sig_rd;
    logic [DATA_W-1:0] rd_mux;
    logic              valid_q;
    logic              denied_q;
    logic [DATA_W-1:0] data_q;

    assign op    = cfg_op_e'(cmd_op);
    assign gated = locked && (op == OP_PAT_RD || op == OP_PRELOAD);

    plc_cfg_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (cmd_valid && op == OP_LOCK),
        .clr_i    (cmd_valid && op == OP_ERASE),
        .locked_o (locked)
    );

    plc_cfg_bytes #(.WORDS(PAT_WORDS), .WIDTH(DATA_W)) u_pattern (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cmd_valid && op == OP_PAT_WR),
        .wr_addr (cmd_addr),
        .wr_data (cmd_wdata),
        .clr     (cmd_valid && op == OP_ERASE),
        .rd_addr (cmd_addr),
        .rd_data (pat_rd)
    );

    plc_cfg_bytes #(.WORDS(SIG_BYTES), .WIDTH(DATA_W)) u_signature (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cmd_valid && op == OP_SIG_WR),
        .wr_addr (cmd_addr[SW-1:0]),
        .wr_data (cmd_wdata),
        .clr     (1'b0),
        .rd_addr (cmd_addr[SW-1:0]),
        .rd_data (sig_rd)
    );

    plc_cfg_preload #(.NREG(NREG)) u_preload (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (cmd_valid && op == OP_PRELOAD && !locked),
        .idx_i    (cmd_addr[IW-1:0]),
        .val_i    (cmd_wdata[0]),
        .strobe_o (pre_load),
        .data_o   (pre_data)
    );

    // Read-data selection: only ungated reads return stored bytes.
    always_comb begin
        rd_mux = '0;
        if (op == OP_PAT_RD && !locked) rd_mux = pat_rd;
        else if (op == OP_SIG_RD)       rd_mux = sig_rd;
    end

    // Response register: one pulse per accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            denied_q <= 1'b0;
            data_q   <= '0;
        end else begin
            valid_q  <= cmd_valid;
            denied_q <= cmd_valid && gated;
            data_q   <= cmd_valid ? rd_mux : '0;
        end
    end

    assign rsp_valid  = valid_q;
    assign rsp_denied = denied_q;
    assign rsp_rdata  = data_q;

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);
    assert_locked_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_PAT_RD && locked) |=> (rsp_denied && rsp_rdata == '0));
    assert_locked_preload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_PRELOAD && locked) |=> (rsp_denied && pre_load == '0));
    assert_signature_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (op == OP_SIG_RD || op == OP_SIG_WR)) |=> !rsp_denied);
    assert_strobe_with_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_load != '0) |-> rsp_valid);
endmodule

// File: tb/plc_cfg_access_bench.sv
module plc_cfg_access_bench;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_wdata = '0;
    logic          rsp_valid;
    logic [7:0]    rsp_rdata;
    logic          rsp_denied;
    logic [7:0]    pre_load;
    logic [7:0]    pre_data;

    plc_cfg_access u_plc_cfg_access (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_denied(rsp_denied), .pre_load(pre_load),
        .pre_data(pre_data)
    );

    always #2 clk = ~clk;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    logic [7:0] m_pat [32];
    logic [7:0] m_sig [8];
    logic       m_lock;
    logic [7:0] m_pre;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] op, input logic lk);
        case (op)
            3'd0: return "R3";
            3'd1: return lk ? "R6" : "R3";
            3'd2: return lk ? "R7" : "R4";
            3'd3, 3'd4: return "R8";
            3'd5: return "R5";
            3'd6: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Drives one command now (just after a falling edge) and checks its response.
    task automatic run_cmd(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d);
        logic [7:0] e_data;
        logic       e_den;
        logic [7:0] e_load;
        string      tg;
        e_data = '0; e_den = 1'b0; e_load = '0;
        tg = tag_of(op, m_lock);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        case (op)
            3'd0: m_pat[a] = d;
            3'd1: if (m_lock) e_den = 1'b1; else e_data = m_pat[a];
            3'd2: if (m_lock) e_den = 1'b1;
                  else begin e_load[a[2:0]] = 1'b1; m_pre[a[2:0]] = d[0]; end
            3'd3: e_data = m_sig[a[2:0]];
            3'd4: m_sig[a[2:0]] = d;
            3'd5: m_lock = 1'b1;
            3'd6: begin m_lock = 1'b0; for (int i = 0; i < 32; i++) m_pat[i] = '0; end
            default: ;
        endcase
        @(negedge clk);
        cmd_valid = 1'b0;
        check(rsp_valid === 1'b1, "R2 rsp_valid", 32'(rsp_valid), 1);
        check(rsp_rdata === e_data && rsp_denied === e_den, tg,
              {23'd0, rsp_denied, rsp_rdata}, {23'd0, e_den, e_data});
        check(pre_load === e_load && pre_data === m_pre, tg,
              {16'd0, pre_load, pre_data}, {16'd0, e_load, m_pre});
    endtask

    task automatic idle();
        cmd_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid === 1'b0 && pre_load === '0, "R2 idle",
              {23'd0, rsp_valid, pre_load}, 0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
        for (int i = 0; i < 32; i++) m_pat[i] = '0;
        for (int i = 0; i < 8; i++) m_sig[i] = '0;
        m_lock = 1'b0;
        m_pre = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        check(rsp_valid === 1'b0 && pre_load === '0 && pre_data === '0, "R1",
              {15'd0, rsp_valid, pre_load, pre_data}, 0);
        run_cmd(3'd1, 5'd17, 8'h00);   // R1: blank pattern
        run_cmd(3'd3, 5'd6, 8'h00);    // R1: blank signature
        run_cmd(3'd2, 5'd9, 8'h00);    // R1: lock clear, preload honoured
        // R3 pattern write/read, back to back
        run_cmd(3'd0, 5'd31, 8'hA5);
        run_cmd(3'd1, 5'd31, 8'h00);
        run_cmd(3'd0, 5'd0, 8'h3C);
        run_cmd(3'd1, 5'd0, 8'h00);
        // R4 preload high then low on extreme lanes
        run_cmd(3'd2, 5'd7, 8'h01);
        run_cmd(3'd2, 5'd0, 8'hFF);
        run_cmd(3'd2, 5'd7, 8'hFE);
        idle();                        // R2 gap
        run_cmd(3'd4, 5'd3, 8'h77);    // R8 write before lock
        // R5: lock then immediate refused read and preload
        run_cmd(3'd5, 5'd0, 8'h00);
        run_cmd(3'd1, 5'd31, 8'h00);   // R6
        run_cmd(3'd2, 5'd0, 8'h00);    // R7
        run_cmd(3'd0, 5'd4, 8'h99);    // R3 write while locked
        run_cmd(3'd3, 5'd3, 8'h00);    // R8 read while locked
        run_cmd(3'd4, 5'd5, 8'hC1);    // R8 write while locked
        run_cmd(3'd3, 5'd5, 8'h00);
        run_cmd(3'd7, 5'd2, 8'hFF);    // R10 reserved
        // R9 erase: lock off, pattern blank, signature kept
        run_cmd(3'd6, 5'd0, 8'h00);
        run_cmd(3'd1, 5'd4, 8'h00);
        run_cmd(3'd1, 5'd31, 8'h00);
        run_cmd(3'd3, 5'd3, 8'h00);
        run_cmd(3'd2, 5'd4, 8'h01);
        // Random mix
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            logic [2:0]  op;
            logic [AW-1:0] a;
            r = $urandom % 32;
            a = (($urandom % 2) == 0) ? AW'($urandom % 8) : AW'($urandom);
            if (r < 6)       op = 3'd0;
            else if (r < 12) op = 3'd1;
            else if (r < 17) op = 3'd2;
            else if (r < 21) op = 3'd3;
            else if (r < 25) op = 3'd4;
            else if (r < 27) op = 3'd5;
            else if (r < 28) op = 3'd6;
            else if (r < 29) op = 3'd7;
            else             op = 3'd0;
            if (r == 31) idle();
            else run_cmd(op, a, 8'($urandom));
        end
        idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule